// File: doc/BRIEF.md
# Multi-Queue Transmit Channel Scheduler

This block decides, on every clock, which transmit descriptor leaves next. Sixteen circular descriptor rings are tracked as pairs of indices. The host owns each tail index and drives it in. The scheduler owns each head index and advances it on every issue. Each ring is bound through a programmable field to one of eight outbound DMA FIFO channels. Several rings may share a channel, but a ring feeds only one channel at a time.

The channels have fixed priorities, and a higher channel number always wins. Channel 7 carries commands and comes ahead of everything else. Channels 3, 2, 1 and 0 carry voice and management, video, best effort and background traffic, in falling priority. Channels 4 to 6 are normally idle, but any ring mapped to them is still served by its channel number. When several rings on one channel have work, they take turns in round-robin order.

Each issue appears one clock after the decision. It shows as a one-hot channel strobe, together with the ring number and the head index of the descriptor taken. The same ring also gets a pop pulse in that clock.

Top module: `txsched_top`

## Requirements
- R1: During and after reset, every head index is 0, `ch_valid_o` and `q_pop_o` are 0, and ring q is mapped to channel q for q < 7 and to channel q mod 4 for q >= 7.
- R2: Ring q is eligible only when `q_active_i[q]` is 1 and its head index differs from `q_tail_i[q*8 +: 8]`. `q_nonempty_o[q]` is 1 exactly when the head and tail differ, whatever the active bit.
- R3: At most one descriptor is issued per clock. `ch_valid_o` and `q_pop_o` are each one-hot or zero, and they are nonzero in the same cycle. An issue on channel c appears in the cycle after a clock edge at which `ch_ready_i[c]` was 1.
- R4: Among channels that have their ready bit at 1 and at least one eligible ring, the highest channel number is served. Channel 7 (commands) beats all others, and 3 > 2 > 1 > 0 among the traffic classes.
- R5: Within a channel, the search starts at the ring after the one it last granted, wraps from 15 to 0, and takes the first eligible ring mapped to that channel. Each channel's pointer starts at ring 0.
- R6: On an issue, `desc_qid_o` is the ring number and `desc_idx_o` is that ring's head index before the issue. The head index, seen on `q_head_o[q*8 +: 8]`, then advances by one modulo 256.
- R7: A write with `cfg_we` = 1 sets ring `cfg_qid` to channel `cfg_ch` only when that ring's active bit is 0 at the same clock edge. Otherwise the write is ignored. A grant in the cycle of a write still uses the mapping from before the write.
- R8: A ring is only ever issued on the channel it is mapped to. Several rings may be mapped to the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Mapping write strobe |
| cfg_qid | input | 4 | Ring selected by a mapping write |
| cfg_ch | input | 3 | New channel for that ring |
| q_active_i | input | 16 | Active bit of each ring |
| q_tail_i | input | 128 | Tail index of each ring, 8 bits per ring, ring q at bits q*8 and up |
| q_head_o | output | 128 | Head index of each ring, same packing |
| q_nonempty_o | output | 16 | Head differs from tail, per ring |
| q_pop_o | output | 16 | One-hot pulse marking the ring just issued |
| ch_ready_i | input | 8 | Downstream FIFO channel can take a descriptor |
| ch_valid_o | output | 8 | One-hot strobe of the channel receiving the descriptor |
| desc_qid_o | output | 4 | Ring number of the issued descriptor |
| desc_idx_o | output | 8 | Ring slot of the issued descriptor |

## Verification
Two things can happen on the same edge: a mapping write, and a grant on the channel that the write names or on the ring it targets. The pseudo-random sweep keeps most channels ready and fires writes to random rings and channels while rings are busy. This makes writes to active rings that are being served, and writes that move an idle ring onto a channel issuing in that very cycle. A bench model judges each edge. It computes the grant from the mapping as it stood before the write, applies the write only if the target ring was idle, and then compares the strobe, ring number, slot, pop and head at the ports. A directed case also repeats this on ring 5 with explicit channel values.

// File: rtl/txs_pkg.sv
// Package txs_pkg
// Shared helpers for the transmit scheduler.
// Assumes ring counts and channel counts stay small enough to loop over.
package txs_pkg;

    // Home channel of a ring after reset: identity for the first rings,
    // folded onto the traffic-class channels for the rest.
    function automatic int txs_home_chan(input int q, input int fixed_n, input int tc_n);
        return (q < fixed_n) ? q : (q % tc_n);
    endfunction

endpackage

// File: rtl/txs_map_regs.sv
// Module txs_map_regs
// Holds the ring-to-channel mapping, one field per ring.
// Assumes the host only remaps a ring while its active bit is low; writes
// aimed at an active ring are dropped.
module txs_map_regs #(
    parameter int NUM_Q   = 16,
    parameter int CH_W    = 3,
    parameter int QID_W   = 4,
    parameter int FIXED_Q = 7,
    parameter int TC_CH   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [QID_W-1:0]            cfg_qid,
    input  logic [CH_W-1:0]             cfg_ch,
    input  logic [NUM_Q-1:0]            q_active_i,
    output logic [NUM_Q-1:0][CH_W-1:0]  map_o
);

    for (genvar g = 0; g < NUM_Q; g++) begin : g_field
        // Load the home channel on reset; accept a write only while the ring is idle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_o[g] <= CH_W'(txs_pkg::txs_home_chan(g, FIXED_Q, TC_CH));
            else if (cfg_we && (cfg_qid == QID_W'(g)) && !q_active_i[g])
                map_o[g] <= cfg_ch;
        end
    end

    AST_MAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && q_active_i[cfg_qid]) |=> (map_o == $past(map_o))); // R7

endmodule

// File: rtl/txs_ring_heads.sv
// Module txs_ring_heads
// Owns the head index of every ring and advances it on a grant.
// Assumes grant_i is one-hot or zero and comes from the same cycle's arbitration.
module txs_ring_heads #(
    parameter int NUM_Q = 16,
    parameter int PTR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_Q-1:0]             grant_i,
    output logic [NUM_Q-1:0][PTR_W-1:0]  head_o
);

    for (genvar g = 0; g < NUM_Q; g++) begin : g_head
        // Clear on reset; step by one, wrapping at the ring size, when granted.
        always_ff @(posedge clk) begin
            if (!rst_n)
                head_o[g] <= '0;
            else if (grant_i[g])
                head_o[g] <= head_o[g] + PTR_W'(1);
        end

        AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            grant_i[g] |=> (head_o[g] == PTR_W'($past(head_o[g]) + PTR_W'(1)))); // R6
        AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !grant_i[g] |=> $stable(head_o[g])); // R6
    end

endmodule

// File: rtl/txs_rr_pick.sv
// Module txs_rr_pick
// Round-robin picker for one channel: finds the first requesting ring at or
// after the start pointer, wrapping around the ring count.
// Assumes ptr_i < NUM_Q. Purely combinational.
module txs_rr_pick #(
    parameter int NUM_Q = 16,
    parameter int QID_W = 4
) (
    input  logic [NUM_Q-1:0] req_i,
    input  logic [QID_W-1:0] ptr_i,
    output logic             any_o,
    output logic [QID_W-1:0] sel_o
);

    // Scan from the farthest offset down so the nearest request wins.
    always_comb begin
        any_o = 1'b0;
        sel_o = '0;
        for (int i = NUM_Q - 1; i >= 0; i--) begin
            int idx;
            idx = int'(ptr_i) + i;
            if (idx >= NUM_Q)
                idx = idx - NUM_Q;
            if (req_i[idx]) begin
                any_o = 1'b1;
                sel_o = QID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/txsched_top.sv
// Module txsched_top
// Transmit scheduler: picks at most one descriptor per clock from the rings,
// first by fixed channel priority (higher channel number wins), then
// round-robin among the rings on that channel. The issue is registered.
// Assumes a channel that raises ready accepts the strobe in the next cycle.
module txsched_top #(
    parameter int NUM_Q   = 16,
    parameter int NUM_CH  = 8,
    parameter int PTR_W   = 8,
    parameter int FIXED_Q = 7,
    parameter int TC_CH   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [$clog2(NUM_Q)-1:0]  cfg_qid,
    input  logic [$clog2(NUM_CH)-1:0] cfg_ch,
    input  logic [NUM_Q-1:0]         q_active_i,
    input  logic [NUM_Q*PTR_W-1:0]   q_tail_i,
    output logic [NUM_Q*PTR_W-1:0]   q_head_o,
    output logic [NUM_Q-1:0]         q_nonempty_o,
    output logic [NUM_Q-1:0]         q_pop_o,
    input  logic [NUM_CH-1:0]        ch_ready_i,
    output logic [NUM_CH-1:0]        ch_valid_o,
    output logic [$clog2(NUM_Q)-1:0]  desc_qid_o,
    output logic [PTR_W-1:0]         desc_idx_o
);

    localparam int QID_W = $clog2(NUM_Q);
    localparam int CH_W  = $clog2(NUM_CH);

    logic [NUM_Q-1:0][PTR_W-1:0]  head_w;
    logic [NUM_Q-1:0][PTR_W-1:0]  tail_w;
    logic [NUM_Q-1:0][CH_W-1:0]   map_w;
    logic [NUM_Q-1:0]             elig_w;
    logic [NUM_CH-1:0]            ch_any_w;
    logic [QID_W-1:0]             ch_sel_w [NUM_CH];
    logic [NUM_CH-1:0][QID_W-1:0] rr_ptr_q;
    logic                         found_w;
    logic [CH_W-1:0]              win_ch_w;
    logic [QID_W-1:0]             win_q_w;
    logic [NUM_Q-1:0]             grant_w;

    assign tail_w   = q_tail_i;
    assign q_head_o = head_w;

    txs_ring_heads #(.NUM_Q(NUM_Q), .PTR_W(PTR_W)) u_heads (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant_i (grant_w),
        .head_o  (head_w)
    );

    txs_map_regs #(.NUM_Q(NUM_Q), .CH_W(CH_W), .QID_W(QID_W),
                   .FIXED_Q(FIXED_Q), .TC_CH(TC_CH)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_qid    (cfg_qid),
        .cfg_ch     (cfg_ch),
        .q_active_i (q_active_i),
        .map_o      (map_w)
    );

    // Per-ring occupancy and eligibility.
    always_comb begin
        for (int q = 0; q < NUM_Q; q++) begin
            q_nonempty_o[q] = (head_w[q] != tail_w[q]);
            elig_w[q]       = q_active_i[q] && q_nonempty_o[q];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic [NUM_Q-1:0] req_c;

        // Gather the eligible rings mapped to this channel.
        always_comb begin
            for (int q = 0; q < NUM_Q; q++)
                req_c[q] = elig_w[q] && (map_w[q] == CH_W'(c));
        end

        txs_rr_pick #(.NUM_Q(NUM_Q), .QID_W(QID_W)) u_pick (
            .req_i (req_c),
            .ptr_i (rr_ptr_q[c]),
            .any_o (ch_any_w[c]),
            .sel_o (ch_sel_w[c])
        );

        // Move this channel's turn pointer past the ring it just served.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rr_ptr_q[c] <= '0;
            else if (found_w && (win_ch_w == CH_W'(c)))
                rr_ptr_q[c] <= (win_q_w == QID_W'(NUM_Q - 1)) ? '0 : win_q_w + QID_W'(1);
        end
    end

    // Fixed priority across channels: the highest ready channel with work wins.
    always_comb begin
        found_w  = 1'b0;
        win_ch_w = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_any_w[c] && ch_ready_i[c]) begin
                found_w  = 1'b1;
                win_ch_w = CH_W'(c);
            end
        end
        win_q_w = ch_sel_w[win_ch_w];
        grant_w = found_w ? (NUM_Q'(1) << win_q_w) : '0;
    end

    // Register the issue: channel strobe, descriptor fields and pop pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_valid_o <= '0;
            q_pop_o    <= '0;
            desc_qid_o <= '0;
            desc_idx_o <= '0;
        end else begin
            ch_valid_o <= found_w ? (NUM_CH'(1) << win_ch_w) : '0;
            q_pop_o    <= grant_w;
            if (found_w) begin
                desc_qid_o <= win_q_w;
                desc_idx_o <= head_w[win_q_w];
            end
        end
    end

    AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_valid_o)); // R3
    AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_pop_o)); // R3
    AST_POP_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|q_pop_o) == (|ch_valid_o))); // R3
    AST_READY_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_valid_o) |-> ((ch_valid_o & $past(ch_ready_i)) == ch_valid_o)); // R3
    AST_POP_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|q_pop_o) |-> ((q_pop_o & ~$past(elig_w)) == '0)); // R2

endmodule

// File: tb/tb_txsched_top.sv
module tb_txsched_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_qid = '0;
    logic [2:0]   cfg_ch = '0;
    logic [15:0]  q_active_i = '0;
    logic [127:0] q_tail_i = '0;
    logic [127:0] q_head_o;
    logic [15:0]  q_nonempty_o;
    logic [15:0]  q_pop_o;
    logic [7:0]   ch_ready_i = '0;
    logic [7:0]   ch_valid_o;
    logic [3:0]   desc_qid_o;
    logic [7:0]   desc_idx_o;

    int total = 0;
    int bad = 0;

    logic [7:0]  m_head [16];
    logic [7:0]  m_tail [16];
    logic [2:0]  m_map  [16];
    int          m_rr   [8];
    logic [15:0] m_act;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    txsched_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_ch(cfg_ch),
        .q_active_i(q_active_i), .q_tail_i(q_tail_i), .q_head_o(q_head_o),
        .q_nonempty_o(q_nonempty_o), .q_pop_o(q_pop_o), .ch_ready_i(ch_ready_i),
        .ch_valid_o(ch_valid_o), .desc_qid_o(desc_qid_o), .desc_idx_o(desc_idx_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive();
        q_active_i = m_act;
        for (int q = 0; q < 16; q++) q_tail_i[q*8 +: 8] = m_tail[q];
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    // One clock: predict the grant from the requirements, then check the ports.
    task automatic cycle(input string tag);
        bit         found;
        int         ec;
        int         eq;
        logic [7:0] eidx;
        found = 0; ec = 0; eq = 0;
        drive();
        for (int c = 7; c >= 0; c--) begin
            if (!found && ch_ready_i[c]) begin
                for (int i = 0; i < 16; i++) begin
                    int q;
                    q = (m_rr[c] + i) % 16;
                    if (!found && m_act[q] && (m_head[q] != m_tail[q]) && (m_map[q] == 3'(c))) begin
                        found = 1; ec = c; eq = q;
                    end
                end
            end
        end
        eidx = m_head[eq];
        if (cfg_we && !m_act[cfg_qid]) m_map[cfg_qid] = cfg_ch;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(ch_valid_o == (found ? (8'(1) << ec) : 8'h0), {tag, " R3 strobe"}, 32'(ch_valid_o),
            found ? (32'(1) << ec) : 32'h0);
        chk(q_pop_o == (found ? (16'(1) << eq) : 16'h0), {tag, " R3 pop"}, 32'(q_pop_o),
            found ? (32'(1) << eq) : 32'h0);
        if (found) begin
            m_head[eq] = m_head[eq] + 8'd1;
            m_rr[ec]   = (eq + 1) % 16;
            chk(desc_qid_o == 4'(eq), {tag, " R6 qid"}, 32'(desc_qid_o), 32'(eq));
            chk(desc_idx_o == eidx, {tag, " R6 idx"}, 32'(desc_idx_o), 32'(eidx));
            chk(q_head_o[eq*8 +: 8] == m_head[eq], {tag, " R6 head"}, 32'(q_head_o[eq*8 +: 8]),
                32'(m_head[eq]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seq_pri [5];
        int seq_rr  [6];
        seq_pri = '{10, 3, 2, 1, 0};
        seq_rr  = '{8, 12, 0, 8, 12, 0};
        for (int q = 0; q < 16; q++) begin
            m_head[q] = '0; m_tail[q] = '0;
            m_map[q] = (q < 7) ? 3'(q) : 3'(q % 4);
        end
        for (int c = 0; c < 8; c++) m_rr[c] = 0;
        m_act = '0;
        drive();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ch_valid_o == 8'h0, "R1 strobe", 32'(ch_valid_o), 0);
        chk(q_pop_o == 16'h0, "R1 pop", 32'(q_pop_o), 0);
        chk(q_head_o == '0, "R1 heads", q_head_o[31:0], 0);
        rst_n = 1'b1;

        // R1/R8 default mapping: ring 9 lands on channel 1
        ch_ready_i = 8'hFF;
        m_tail[9] = 8'd1; m_act[9] = 1'b1;
        cycle("R1");
        chk(ch_valid_o == 8'h02, "R8 default map ring 9", 32'(ch_valid_o), 32'h02);
        m_act[9] = 1'b0;

        // R2: inactive ring with data, active ring without
        m_tail[6] = 8'd1; m_act[4] = 1'b1;
        cycle("R2");
        chk(ch_valid_o == 8'h00, "R2 nothing eligible", 32'(ch_valid_o), 0);
        chk(q_nonempty_o[6] == 1'b1, "R2 nonempty inactive", 32'(q_nonempty_o[6]), 1);
        chk(q_nonempty_o[4] == 1'b0, "R2 empty active", 32'(q_nonempty_o[4]), 0);
        m_act[4] = 1'b0; m_tail[6] = 8'd0;
        cycle("R2");  // ring 6 head 0, tail 0 again

        // R7 allowed write, then R4 priority: ring 10 on command channel first
        cfg_we = 1'b1; cfg_qid = 4'd10; cfg_ch = 3'd7;
        cycle("R7");
        for (int q = 0; q < 4; q++) begin m_tail[q] = 8'd1; m_act[q] = 1'b1; end
        m_tail[10] = 8'd1; m_act[10] = 1'b1;
        for (int k = 0; k < 5; k++) begin
            cycle("R4");
            chk(desc_qid_o == 4'(seq_pri[k]), "R4 priority order", 32'(desc_qid_o), 32'(seq_pri[k]));
        end
        // R4 ready gating: channel 3 not ready, channel 2 served
        m_tail[3] = 8'd2; m_tail[2] = 8'd2;
        ch_ready_i = 8'hF7;
        cycle("R4");
        chk(ch_valid_o == 8'h04, "R4 ready gating", 32'(ch_valid_o), 32'h04);
        ch_ready_i = 8'hFF;
        cycle("R4");
        chk(ch_valid_o == 8'h08, "R4 voice after ready", 32'(ch_valid_o), 32'h08);

        // R5 round-robin on channel 0: rings 0, 8, 12
        m_tail[0] = 8'd3; m_tail[8] = 8'd2; m_tail[12] = 8'd2;
        m_act[8] = 1'b1; m_act[12] = 1'b1;
        ch_ready_i = 8'h01;
        for (int k = 0; k < 6; k++) begin
            cycle("R5");
            chk(desc_qid_o == 4'(seq_rr[k]), "R5 turn order", 32'(desc_qid_o), 32'(seq_rr[k]));
        end
        cycle("R5");
        chk(ch_valid_o == 8'h00, "R5 drained", 32'(ch_valid_o), 0);

        // R6 wrap of ring 5
        ch_ready_i = 8'hFF;
        m_act = 16'h0020;
        m_tail[5] = 8'd255;
        for (int k = 0; k < 255; k++) cycle("R6");
        m_tail[5] = 8'd2;
        for (int k = 0; k < 3; k++) begin
            cycle("R6");
            chk(desc_idx_o == 8'(255 + k), "R6 wrap slot", 32'(desc_idx_o), 32'(8'(255 + k)));
        end

        // R7: write to an active ring in the cycle it is served is ignored
        m_tail[5] = 8'd4;
        cfg_we = 1'b1; cfg_qid = 4'd5; cfg_ch = 3'd2;
        cycle("R7");
        cycle("R7");
        chk(ch_valid_o == 8'h20, "R7 locked map", 32'(ch_valid_o), 32'h20);
        m_act[5] = 1'b0;
        cfg_we = 1'b1; cfg_qid = 4'd5; cfg_ch = 3'd2;
        cycle("R7");
        m_act[5] = 1'b1; m_tail[5] = 8'd5;
        cycle("R7");
        chk(ch_valid_o == 8'h04, "R7 idle remap", 32'(ch_valid_o), 32'h04);

        // Sweep: random readiness, activity, tails and remaps against the model
        for (int n = 0; n < 4000; n++) begin
            int q;
            step_lfsr();
            ch_ready_i = lfsr[3] ? 8'hFF : lfsr[15:8];
            q = int'(lfsr[19:16]);
            if (lfsr[22:20] == 3'd0) m_act[q] = ~m_act[q];
            step_lfsr();
            q = int'(lfsr[7:4]);
            if (lfsr[0] && (8'(m_tail[q] - m_head[q]) < 8'd200))
                m_tail[q] = m_tail[q] + 8'(lfsr[9:8]) + 8'd1;
            if (lfsr[13:12] == 2'd0) begin
                cfg_we = 1'b1; cfg_qid = lfsr[19:16]; cfg_ch = lfsr[26:24];
            end
            cycle("R8 sweep");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule